// File: doc/BRIEF.md
# Two-Channel I/O Conditional-Search Qualifier

This block watches two general-purpose I/O pins and decides whether a device should answer a conditional search on a single-wire network. Each pin passes through a two-flop synchronizer and a pulse-width filter. The filtered level feeds an activity latch for that channel. The latch records any accepted level change, in either direction, and holds it until it is explicitly cleared.

Software sets three things for the decision: which channels take part (a selection mask), the level each channel must show (a polarity word), and whether the channel source is the filtered pin or the activity latch. A combine bit then picks between two rules. In OR mode, any one qualifying channel is enough. In AND mode, every selected channel must qualify. A sticky power-on flag forces the response high until software clears it.

Six byte registers sit at a configurable base address (default 220h):

| Offset | Register |
|--------|----------|
| 0 | Filtered pin state |
| 1 | Output latch |
| 2 | Activity latches |
| 3 | Selection mask |
| 4 | Polarity |
| 5 | Control/status |

An activity-clear strobe empties the activity latches, and the synchronous reset acts as the power-on reset.

Top module: `pio_cond_qual`

## Requirements
- R1: After reset, the activity latches, selection mask and polarity read 00h, and the source-select and combine bits are 0.
- R2: A channel's activity latch sets when its synchronized pin holds a new level for at least MIN_PW consecutive clocks (default 4). A level held for fewer clocks is ignored and does not change the filtered state.
- R3: An activity latch stays set until `act_clr` is pulsed, and `act_clr` then returns it to 0. If a new accepted change arrives in the same clock as `act_clr`, the latch stays set.
- R4: The pin-state register (offset 0) and the output-latch register (offset 1) return the channel values in bits 1:0 (bit n = channel n) and 1 in bits 7:2. A write to offset 1 loads bits 1:0 into the output latch, which drives `out_latch`.
- R5: The activity register (offset 2) returns the latches in bits 1:0 and 0 in bits 7:2.
- R6: The mask (offset 3) and polarity (offset 4) store only bits 1:0 of a write. Bits 7:2 always read 0.
- R7: In the control register (offset 5):
  - Bit 0 selects the source: 0 = pin, 1 = activity latch.
  - Bit 1 selects the combine rule: 0 = OR, 1 = AND.
  - Bit 3 is the power-on flag.
  - Bit 6 reflects `pol_strap` and bit 7 reflects `vcc_ok`.
  - Bits 2, 4 and 5 read 0.
  - A write changes only bits 0, 1 and 3.
- R8: The power-on flag is 1 after reset. Writing 0 to bit 3 clears it, and writing 1 never sets it again. While the flag is 1, `cs_resp` is 1.
- R9: In OR mode with the flag clear, `cs_resp` is 1 exactly when at least one masked channel's source equals its polarity bit. `cs_resp` is registered and follows a register change one clock later.
- R10: In AND mode with the flag clear, `cs_resp` is 1 exactly when every masked channel's source equals its polarity bit.
- R11: With the source-select bit at 1, the activity latches are compared in place of the filtered pins.
- R12: With an empty mask and the flag clear, `cs_resp` is 0 in both OR and AND modes.
- R13: At reset, every output-latch bit takes the value of `pol_strap`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| pin_in | input | NCH | Asynchronous pin levels |
| pol_strap | input | 1 | Power-up polarity strap for the output latches |
| vcc_ok | input | 1 | External supply present |
| act_clr | input | 1 | One-clock strobe that clears the activity latches |
| reg_addr | input | ADDR_W | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data for the address of the previous clock |
| out_latch | output | NCH | Output-latch state |
| cs_resp | output | 1 | Registered conditional-search response |

## Verification
The filter is tested at its boundary. A pulse one clock shorter than MIN_PW must leave the activity register at zero, and a pulse of exactly MIN_PW must set it. An off-by-one counter would either miss the legal pulse or accept the short one.

The power-on flag is written with 1 after it has been cleared. A design that treats bit 3 as an ordinary read-write bit would re-arm the forced response.

The empty-mask case is checked in AND mode, where a plain reduction AND over the channels would wrongly answer 1. The same mask, polarity and combine bit are tried with pin and latch sources that differ, so a design that ignores the source select returns the wrong answer.

// File: rtl/pio_cq_pkg.sv
package pio_cq_pkg;
  localparam int REG_W = 8;
  localparam int NREG  = 6;

  typedef enum logic [2:0] {
    SEL_PIN  = 3'd0,
    SEL_OUT  = 3'd1,
    SEL_ACT  = 3'd2,
    SEL_MASK = 3'd3,
    SEL_POL  = 3'd4,
    SEL_CTL  = 3'd5,
    SEL_NONE = 3'd7
  } reg_sel_e;

  // control/status bit positions
  localparam int CTL_SRC  = 0;
  localparam int CTL_AND  = 1;
  localparam int CTL_PWR  = 3;
  localparam int CTL_STRP = 6;
  localparam int CTL_VCC  = 7;
endpackage

// File: rtl/pio_cq_chan.sv
module pio_cq_chan #(
  parameter int MIN_PW = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  input  logic act_clr,
  output logic level,
  output logic act
);
  localparam int CNT_W = (MIN_PW < 2) ? 1 : $clog2(MIN_PW + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(MIN_PW - 1);

  logic             sync1, sync2, lvl_q, act_q;
  logic [CNT_W-1:0] run_q;
  logic             differs, accept;

  assign differs = (sync2 != lvl_q);
  assign accept  = differs && (run_q == CNT_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      // pipeline tracks the pin during reset so no change is seen at release
      sync1 <= pin;
      sync2 <= sync1;
      lvl_q <= sync2;
      run_q <= '0;
      act_q <= 1'b0;
    end else begin
      sync1 <= pin;
      sync2 <= sync1;
      if (accept) begin
        lvl_q <= sync2;
        run_q <= '0;
      end else if (differs) begin
        run_q <= run_q + CNT_W'(1);
      end else begin
        run_q <= '0;
      end
      if (accept)       act_q <= 1'b1;
      else if (act_clr) act_q <= 1'b0;
    end
  end

  assign level = lvl_q;
  assign act   = act_q;
endmodule

// File: rtl/pio_cq_regs.sv
module pio_cq_regs
  import pio_cq_pkg::*;
#(
  parameter int NCH    = 2,
  parameter int ADDR_W = 10,
  parameter int BASE   = 'h220
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [REG_W-1:0]  reg_wdata,
  input  logic              pol_strap,
  input  logic              vcc_ok,
  input  logic [NCH-1:0]    pin_lvl,
  input  logic [NCH-1:0]    act,
  output logic [REG_W-1:0]  reg_rdata,
  output logic [NCH-1:0]    out_latch,
  output logic [NCH-1:0]    mask,
  output logic [NCH-1:0]    pol,
  output logic              src_act,
  output logic              use_and,
  output logic              pwr_flag
);
  localparam int PAD = REG_W - NCH;

  logic [ADDR_W-1:0] off;
  reg_sel_e          sel;
  logic [REG_W-1:0]  rd_mux;

  assign off = reg_addr - ADDR_W'(BASE);

  always_comb begin
    if (off < ADDR_W'(NREG)) sel = reg_sel_e'(off[2:0]);
    else                     sel = SEL_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_latch <= {NCH{pol_strap}};
      mask      <= '0;
      pol       <= '0;
      src_act   <= 1'b0;
      use_and   <= 1'b0;
      pwr_flag  <= 1'b1;
    end else if (reg_wr) begin
      unique case (sel)
        SEL_OUT:  out_latch <= reg_wdata[NCH-1:0];
        SEL_MASK: mask      <= reg_wdata[NCH-1:0];
        SEL_POL:  pol       <= reg_wdata[NCH-1:0];
        SEL_CTL: begin
          src_act  <= reg_wdata[CTL_SRC];
          use_and  <= reg_wdata[CTL_AND];
          pwr_flag <= pwr_flag & reg_wdata[CTL_PWR];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_mux = '0;
    unique case (sel)
      SEL_PIN:  rd_mux = {{PAD{1'b1}}, pin_lvl};
      SEL_OUT:  rd_mux = {{PAD{1'b1}}, out_latch};
      SEL_ACT:  rd_mux = {{PAD{1'b0}}, act};
      SEL_MASK: rd_mux = {{PAD{1'b0}}, mask};
      SEL_POL:  rd_mux = {{PAD{1'b0}}, pol};
      SEL_CTL: begin
        rd_mux[CTL_SRC]  = src_act;
        rd_mux[CTL_AND]  = use_and;
        rd_mux[CTL_PWR]  = pwr_flag;
        rd_mux[CTL_STRP] = pol_strap;
        rd_mux[CTL_VCC]  = vcc_ok;
      end
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_mux;
  end
endmodule

// File: rtl/pio_cq_resp.sv
module pio_cq_resp #(
  parameter int NCH = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] pin_lvl,
  input  logic [NCH-1:0] act,
  input  logic [NCH-1:0] mask,
  input  logic [NCH-1:0] pol,
  input  logic           src_act,
  input  logic           use_and,
  input  logic           pwr_flag,
  output logic           resp
);
  logic [NCH-1:0] hit;
  logic [NCH-1:0] ok;
  logic           any_hit, all_ok, next_resp;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic srcv;
    assign srcv   = src_act ? act[c] : pin_lvl[c];
    assign hit[c] = mask[c] & (srcv == pol[c]);
    assign ok[c]  = ~mask[c] | (srcv == pol[c]);
  end

  assign any_hit   = |hit;
  assign all_ok    = (&ok) & (|mask);
  assign next_resp = pwr_flag | (use_and ? all_ok : any_hit);

  always_ff @(posedge clk) begin
    if (rst) resp <= 1'b1;
    else     resp <= next_resp;
  end
endmodule

// File: rtl/pio_cond_qual.sv
module pio_cond_qual #(
  parameter int NCH    = 2,
  parameter int MIN_PW = 4,
  parameter int ADDR_W = 10,
  parameter int BASE   = 'h220
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NCH-1:0]    pin_in,
  input  logic              pol_strap,
  input  logic              vcc_ok,
  input  logic              act_clr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic [NCH-1:0]    out_latch,
  output logic              cs_resp
);
  logic [NCH-1:0] pin_lvl, act_lvl, mask_q, pol_q;
  logic           src_act_q, use_and_q, porl_q;

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    pio_cq_chan #(.MIN_PW(MIN_PW)) u_chan (
      .clk(clk), .rst(rst), .pin(pin_in[c]), .act_clr(act_clr),
      .level(pin_lvl[c]), .act(act_lvl[c])
    );
  end

  pio_cq_regs #(.NCH(NCH), .ADDR_W(ADDR_W), .BASE(BASE)) u_regs (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .pol_strap(pol_strap), .vcc_ok(vcc_ok),
    .pin_lvl(pin_lvl), .act(act_lvl), .reg_rdata(reg_rdata),
    .out_latch(out_latch), .mask(mask_q), .pol(pol_q),
    .src_act(src_act_q), .use_and(use_and_q), .pwr_flag(porl_q)
  );

  pio_cq_resp #(.NCH(NCH)) u_resp (
    .clk(clk), .rst(rst), .pin_lvl(pin_lvl), .act(act_lvl),
    .mask(mask_q), .pol(pol_q), .src_act(src_act_q),
    .use_and(use_and_q), .pwr_flag(porl_q), .resp(cs_resp)
  );
endmodule

// File: rtl/pio_cq_checker.sv
module pio_cq_checker #(
  parameter int NCH    = 2,
  parameter int ADDR_W = 10,
  parameter int BASE   = 'h220
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [7:0]        reg_rdata,
  input logic              act_clr,
  input logic [NCH-1:0]    act_lvl,
  input logic [NCH-1:0]    mask_q,
  input logic              porl_q,
  input logic              pol_strap,
  input logic              vcc_ok,
  input logic              cs_resp
);
  localparam logic [ADDR_W-1:0] A_ACT  = ADDR_W'(BASE + 2);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(BASE + 3);
  localparam logic [ADDR_W-1:0] A_CTL  = ADDR_W'(BASE + 5);

  // R3: without a clear, no set latch may drop
  a_r3_latch_holds: assert property (@(posedge clk) disable iff (rst)
    !act_clr |=> ((act_lvl & $past(act_lvl)) == $past(act_lvl)));

  // R5: activity register upper bits read zero
  a_r5_act_upper: assert property (@(posedge clk) disable iff (rst)
    (reg_addr == A_ACT) |=> (reg_rdata[7:2] == 6'd0));

  // R6: mask register upper bits read zero
  a_r6_mask_upper: assert property (@(posedge clk) disable iff (rst)
    (reg_addr == A_MASK) |=> (reg_rdata[7:2] == 6'd0));

  // R7: status bits mirror straps, unused bits zero
  a_r7_status_bits: assert property (@(posedge clk) disable iff (rst)
    (reg_addr == A_CTL) |=> (reg_rdata[7] == $past(vcc_ok) &&
                             reg_rdata[6] == $past(pol_strap) &&
                             reg_rdata[5:4] == 2'b00 && reg_rdata[2] == 1'b0));

  // R8: flag forces response; once clear it stays clear
  a_r8_flag_forces: assert property (@(posedge clk) disable iff (rst)
    porl_q |=> cs_resp);
  a_r8_flag_no_rearm: assert property (@(posedge clk) disable iff (rst)
    !porl_q |=> !porl_q);

  // R12: empty mask with flag clear gives no response
  a_r12_empty_mask: assert property (@(posedge clk) disable iff (rst)
    (mask_q == '0 && !porl_q) |=> !cs_resp);
endmodule

bind pio_cond_qual pio_cq_checker #(.NCH(NCH), .ADDR_W(ADDR_W), .BASE(BASE)) u_chk (
  .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
  .act_clr(act_clr), .act_lvl(act_lvl), .mask_q(mask_q), .porl_q(porl_q),
  .pol_strap(pol_strap), .vcc_ok(vcc_ok), .cs_resp(cs_resp)
);

// File: tb/pio_cond_qual_tb.sv
module pio_cond_qual_tb;
  localparam int NCH = 2, MIN_PW = 4, ADDR_W = 10, BASE = 'h220;
  localparam int A_PIN = BASE, A_OUT = BASE + 1, A_ACT = BASE + 2;
  localparam int A_MSK = BASE + 3, A_POL = BASE + 4, A_CTL = BASE + 5;

  logic clk = 1'b0, rst = 1'b1;
  logic [NCH-1:0] pin_in = 2'b10;
  logic pol_strap = 1'b1, vcc_ok = 1'b1, act_clr = 1'b0;
  logic [ADDR_W-1:0] reg_addr = '0;
  logic reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [NCH-1:0] out_latch;
  logic cs_resp;
  int nchk = 0, nfail = 0;

  always #4 clk = ~clk;

  pio_cond_qual #(.NCH(NCH), .MIN_PW(MIN_PW), .ADDR_W(ADDR_W), .BASE(BASE)) u_dut (
    .clk(clk), .rst(rst), .pin_in(pin_in), .pol_strap(pol_strap), .vcc_ok(vcc_ok),
    .act_clr(act_clr), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .out_latch(out_latch), .cs_resp(cs_resp)
  );

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic rd(input int a, output logic [7:0] d);
    @(negedge clk); reg_addr = ADDR_W'(a);
    @(negedge clk); d = reg_rdata;
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk); reg_addr = ADDR_W'(a); reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic clear_act();
    @(negedge clk); act_clr = 1'b1;
    @(negedge clk); act_clr = 1'b0;
  endtask

  task automatic pulse(input int ch, input int len);
    @(negedge clk); pin_in[ch] = ~pin_in[ch];
    repeat (len) @(negedge clk);
    pin_in[ch] = ~pin_in[ch];
    repeat (MIN_PW + 6) @(negedge clk);
  endtask

  task automatic resp_is(input string tag, input logic exp);
    @(negedge clk);
    check(tag, {7'd0, cs_resp}, {7'd0, exp});
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check("R8 flag forces resp after reset", {7'd0, cs_resp}, 8'h01);
    rd(A_OUT, d); check("R13 out latch follows strap", d, 8'hFF);
    check("R13 out_latch port", {6'd0, out_latch}, 8'h03);
    rd(A_ACT, d); check("R1 activity clear", d, 8'h00);
    rd(A_MSK, d); check("R1 mask clear", d, 8'h00);
    rd(A_POL, d); check("R1 polarity clear", d, 8'h00);
    rd(A_CTL, d); check("R1 R7 control reset", d, 8'hC8);
    rd(A_PIN, d); check("R4 pin state read", d, 8'hFE);
  endtask

  task automatic t_control();
    logic [7:0] d;
    wr(A_CTL, 8'hFF); rd(A_CTL, d); check("R7 only bits 0,1,3 writable", d, 8'hCB);
    wr(A_CTL, 8'h00); rd(A_CTL, d); check("R8 flag cleared", d, 8'hC0);
    wr(A_CTL, 8'h08); rd(A_CTL, d); check("R8 flag not re-armed", d, 8'hC0);
    wr(A_MSK, 8'hFF); rd(A_MSK, d); check("R6 mask keeps bits 1:0", d, 8'h03);
    wr(A_POL, 8'hFC); rd(A_POL, d); check("R6 polarity drops upper bits", d, 8'h00);
  endtask

  task automatic t_empty_mask();
    wr(A_MSK, 8'h00); wr(A_POL, 8'h00);
    wr(A_CTL, 8'h00); resp_is("R12 empty mask OR", 1'b0);
    wr(A_CTL, 8'h02); resp_is("R12 empty mask AND", 1'b0);
  endtask

  task automatic t_combine();
    // pins: ch1=1, ch0=0
    wr(A_MSK, 8'h03);
    wr(A_CTL, 8'h00); wr(A_POL, 8'h01); resp_is("R9 OR no match", 1'b0);
    wr(A_POL, 8'h03); resp_is("R9 OR one match", 1'b1);
    wr(A_CTL, 8'h02); resp_is("R10 AND partial match", 1'b0);
    wr(A_POL, 8'h02); resp_is("R10 AND full match", 1'b1);
    wr(A_MSK, 8'h01); wr(A_POL, 8'h01); resp_is("R10 AND masked ch0 mismatch", 1'b0);
  endtask

  task automatic t_filter();
    logic [7:0] d;
    clear_act(); rd(A_ACT, d); check("R3 clear strobe", d, 8'h00);
    pulse(0, MIN_PW - 1); rd(A_ACT, d); check("R2 short pulse ignored", d, 8'h00);
    rd(A_PIN, d); check("R2 short pulse leaves pin state", d, 8'hFE);
    pulse(0, MIN_PW); rd(A_ACT, d); check("R2 R5 min pulse latched", d, 8'h01);
    repeat (20) @(negedge clk);
    rd(A_ACT, d); check("R3 latch holds", d, 8'h01);
    clear_act(); rd(A_ACT, d); check("R3 latch cleared", d, 8'h00);
  endtask

  task automatic t_source();
    logic [7:0] d;
    pulse(0, MIN_PW + 2);   // act = 01, pins stay 10
    rd(A_ACT, d); check("R5 activity ch0", d, 8'h01);
    wr(A_MSK, 8'h03); wr(A_POL, 8'h02);
    wr(A_CTL, 8'h02); resp_is("R11 pin source AND", 1'b1);
    wr(A_CTL, 8'h03); resp_is("R11 latch source AND", 1'b0);
    wr(A_POL, 8'h01); resp_is("R11 latch source match", 1'b1);
  endtask

  task automatic t_outlatch();
    logic [7:0] d;
    wr(A_OUT, 8'h01); rd(A_OUT, d); check("R4 out latch write", d, 8'hFD);
    check("R4 out_latch port", {6'd0, out_latch}, 8'h01);
    @(negedge clk); pin_in = 2'b00;
    repeat (MIN_PW + 6) @(negedge clk);
    rd(A_PIN, d); check("R4 pin state follows pins", d, 8'hFC);
  endtask

  initial begin
    #(8 * 200000);
    nfail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (6) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_control();
    t_empty_mask();
    t_combine();
    t_filter();
    t_source();
    t_outlatch();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule